// File: doc/BRIEF.md
# Parallel Port Host Write Handshake Sequencer

This block runs one data or address write from the host side of an enhanced parallel port link. A host-bus I/O write strobe starts it. The block then stalls the host bus by dropping a ready signal and latches the write data and the address/data select. It waits until the peripheral pulls its wait line low. It then turns the port direction to output, drops the write line and pulses either the data strobe or the address strobe. When the peripheral raises the wait line again, the block ends the strobe and releases the host bus.

The peripheral wait line may ring on a long cable. The block passes it through a two-flop synchroniser and then a settling filter, and only a level that has stayed unchanged for a set number of cycles reaches the sequencer. A watchdog of about eleven microseconds aborts a cycle that the peripheral never completes. It sets a sticky status flag, and the host clears that flag with a dedicated input. Once a host write strobe ends, a short hold-off window follows, and any new strobe inside it is ignored. All timing is counted in cycles of a single 100 MHz clock.

Top module: `epp_write_seq`

## Requirements
- R1: After reset, host_ready is 1, port_dir is 1 (input), port_write_n, port_dstb_n and port_astb_n are all 1, and timeout_flag is 0.
- R2: The clock edge that first sees io_wr high after it was low, with the block idle, drives host_ready to 0. The host therefore sees the stall one cycle (10 ns) after the edge that sampled the strobe.
- R3: The wait line counts as changed only after the synchronised level has differed from the filtered level for SETTLE_CYC (5) consecutive cycles. A pulse of the raw wait line shorter than that has no effect on any output.
- R4: port_dir stays 1, and no strobe is asserted, until the filtered wait line is low. After that, port_dir goes to 0 and port_write_n goes to 0 one cycle later.
- R5: port_data shows the write data latched at the start of the cycle, from the cycle after the start until the cycle ends. The strobe falls no earlier than two cycles after port_write_n falls.
- R6: host_sel, sampled at the start edge, chooses the strobe: 0 pulses port_dstb_n and 1 pulses port_astb_n. The other strobe stays 1 for the whole cycle.
- R7: The strobe stays low until the filtered wait line is high. It is released REL_CYC+1 (9) cycles later, which is 12 to 20 cycles after the raw wait line rises. port_write_n and port_dir return to 1 on the same edge.
- R8: host_ready returns to 1 on the same edge that releases the strobe.
- R9: If a cycle has not finished TIMEOUT_CYC (1100) cycles after it starts, the block sets timeout_flag, releases both strobes, the write line and host_ready, and returns toward idle.
- R10: timeout_flag stays 1 until timeout_clr is 1 on a clock edge, and it falls only on such an edge.
- R11: A rising io_wr that occurs within HOLD_CYC (4) cycles after io_wr was seen low at the end of a cycle is ignored. host_ready stays 1 and no new cycle starts until io_wr falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host I/O write strobe, active high |
| host_sel | input | 1 | 1 selects an address write, 0 a data write |
| host_wdata | input | DW | Host write data |
| host_ready | output | 1 | Host bus ready; 0 stalls the host |
| port_data | output | DW | Peripheral data bus |
| port_dir | output | 1 | Port direction; 0 drives out |
| port_write_n | output | 1 | Write line, active low |
| port_dstb_n | output | 1 | Data strobe, active low |
| port_astb_n | output | 1 | Address strobe, active low |
| port_wait_n | input | 1 | Peripheral wait line, asynchronous |
| timeout_flag | output | 1 | Sticky watchdog status |
| timeout_clr | input | 1 | Clears timeout_flag |

## Verification
The hardest situation to reach is ringing on the wait line in the middle of a handshake, while the strobe is already low. The filter must then ignore a short release pulse and still end the strobe on the real release. The stimulus holds a cycle in the strobe phase, raises the raw wait line for two cycles, and confirms that the strobe and ready outputs do not move. Only then does it release the line for good and measure the release window. The hold-off window is reached by dropping and re-raising the host strobe two cycles after a completed cycle. The watchdog is reached by never pulling the wait line low.

// File: rtl/epp_write_pkg.sv
package epp_write_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LOW,
    ST_DIR,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_DONE,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/epp_wait_filter.sv
module epp_wait_filter #(
  parameter int SETTLE_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic filt_out
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      filt_out <= 1'b1;
    end else if (s2_q == filt_out) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(SETTLE_CYC - 1)) begin
      cnt_q    <= '0;
      filt_out <= s2_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/epp_cycle_timer.sv
module epp_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int TIMEOUT_CYC = 1100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/epp_write_seq.sv
module epp_write_seq
  import epp_write_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETTLE_CYC  = 5,
  parameter int SETUP_CYC   = 2,
  parameter int REL_CYC     = 8,
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 1100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] port_data,
  output logic          port_dir,
  output logic          port_write_n,
  output logic          port_dstb_n,
  output logic          port_astb_n,
  input  logic          port_wait_n,
  output logic          timeout_flag,
  input  logic          timeout_clr
);
  localparam int MAXD = (REL_CYC > SETUP_CYC) ?
                        ((REL_CYC > HOLD_CYC) ? REL_CYC : HOLD_CYC) :
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int DLW  = $clog2(MAXD + 1);

  seq_state_t     state_q;
  logic           wait_f;
  logic           wr_prev_q;
  logic           sel_q;
  logic           tmr_load;
  logic [DLW-1:0] tmr_val;
  logic           tmr_zero;
  logic           wd_run;
  logic           wd_expire;
  logic           start;
  logic           set_tmo;

  epp_wait_filter #(.SETTLE_CYC(SETTLE_CYC)) u_filt (
    .clk(clk), .rst(rst), .raw_in(port_wait_n), .filt_out(wait_f)
  );

  epp_cycle_timer #(.W(DLW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  epp_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst(rst), .run(wd_run), .expire(wd_expire)
  );

  assign start  = (state_q == ST_IDLE) && io_wr && !wr_prev_q;
  assign wd_run = (state_q == ST_WAIT_LOW) || (state_q == ST_DIR) ||
                  (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                  (state_q == ST_RELEASE);
  assign set_tmo = wd_run && wd_expire;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!set_tmo) begin
      unique case (state_q)
        ST_DIR: begin
          tmr_load = 1'b1;
          tmr_val  = DLW'(SETUP_CYC - 1);
        end
        ST_STROBE: if (wait_f) begin
          tmr_load = 1'b1;
          tmr_val  = DLW'(REL_CYC - 1);
        end
        ST_DONE: if (!io_wr) begin
          tmr_load = 1'b1;
          tmr_val  = DLW'(HOLD_CYC - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_prev_q <= 1'b0;
    else     wr_prev_q <= io_wr;
  end

  always_ff @(posedge clk) begin
    if (rst)              timeout_flag <= 1'b0;
    else if (set_tmo)     timeout_flag <= 1'b1;
    else if (timeout_clr) timeout_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      host_ready   <= 1'b1;
      port_data    <= '0;
      port_dir     <= 1'b1;
      port_write_n <= 1'b1;
      port_dstb_n  <= 1'b1;
      port_astb_n  <= 1'b1;
      sel_q        <= 1'b0;
    end else if (set_tmo) begin
      state_q      <= ST_DONE;
      host_ready   <= 1'b1;
      port_dir     <= 1'b1;
      port_write_n <= 1'b1;
      port_dstb_n  <= 1'b1;
      port_astb_n  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          host_ready <= 1'b0;
          port_data  <= host_wdata;
          sel_q      <= host_sel;
          state_q    <= ST_WAIT_LOW;
        end
        ST_WAIT_LOW: if (!wait_f) begin
          port_dir <= 1'b0;
          state_q  <= ST_DIR;
        end
        ST_DIR: begin
          port_write_n <= 1'b0;
          state_q      <= ST_SETUP;
        end
        ST_SETUP: if (tmr_zero) begin
          if (sel_q) port_astb_n <= 1'b0;
          else       port_dstb_n <= 1'b0;
          state_q <= ST_STROBE;
        end
        ST_STROBE: if (wait_f) state_q <= ST_RELEASE;
        ST_RELEASE: if (tmr_zero) begin
          port_dstb_n  <= 1'b1;
          port_astb_n  <= 1'b1;
          port_write_n <= 1'b1;
          port_dir     <= 1'b1;
          host_ready   <= 1'b1;
          state_q      <= ST_DONE;
        end
        ST_DONE: if (!io_wr) state_q <= ST_HOLD;
        ST_HOLD: if (tmr_zero) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_write_seq_checker.sv
module epp_write_seq_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic [DW-1:0] port_data,
  input logic          port_dir,
  input logic          port_write_n,
  input logic          port_dstb_n,
  input logic          port_astb_n,
  input logic          timeout_flag,
  input logic          timeout_clr
);
  // R6: never both strobes low
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !(!port_dstb_n && !port_astb_n));

  // R4: a low strobe implies output direction and write line low
  assert_strobe_order_R4: assert property (@(posedge clk) disable iff (rst)
    (!port_dstb_n || !port_astb_n) |-> (!port_dir && !port_write_n));

  // R8: host is stalled while a strobe is low
  assert_stall_during_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!port_dstb_n || !port_astb_n) |-> !host_ready);

  // R5: data does not move while the write line is low
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!port_write_n && !$past(port_write_n)) |-> $stable(port_data));

  // R9: a new timeout leaves the port released
  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> (host_ready && port_dstb_n && port_astb_n && port_write_n));

  // R10: flag falls only after a clear request
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(timeout_flag) |-> $past(timeout_clr));
endmodule

bind epp_write_seq epp_write_seq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .port_data(port_data),
  .port_dir(port_dir), .port_write_n(port_write_n), .port_dstb_n(port_dstb_n),
  .port_astb_n(port_astb_n), .timeout_flag(timeout_flag), .timeout_clr(timeout_clr)
);

// File: tb/test_epp_write_seq.sv
module test_epp_write_seq;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          io_wr = 1'b0;
  logic          host_sel = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ready;
  logic [DW-1:0] port_data;
  logic          port_dir;
  logic          port_write_n;
  logic          port_dstb_n;
  logic          port_astb_n;
  logic          port_wait_n = 1'b1;
  logic          timeout_flag;
  logic          timeout_clr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  epp_write_seq #(.DW(DW)) i_epp_write_seq (
    .clk(clk), .rst(rst), .io_wr(io_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ready(host_ready), .port_data(port_data),
    .port_dir(port_dir), .port_write_n(port_write_n), .port_dstb_n(port_dstb_n),
    .port_astb_n(port_astb_n), .port_wait_n(port_wait_n),
    .timeout_flag(timeout_flag), .timeout_clr(timeout_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full write with measurements; sel picks data (0) or address (1) strobe
  task automatic do_write(input logic sel, input logic [DW-1:0] d);
    int t_dir, t_wr, t_stb, t_rel;
    logic stb;
    @(negedge clk);
    host_sel = sel; host_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    host_wdata = ~d;
    check("R2 ready low after strobe", host_ready, 1'b0);
    cyc(15);
    check("R4 dir held while wait high", port_dir, 1'b1);
    check("R4 no strobe while wait high", port_dstb_n & port_astb_n, 1'b1);
    port_wait_n = 1'b0;
    t_dir = -1; t_wr = -1; t_stb = -1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      stb = sel ? port_astb_n : port_dstb_n;
      if (t_dir < 0 && !port_dir) t_dir = i;
      if (t_wr < 0 && !port_write_n) t_wr = i;
      if (t_stb < 0 && !stb) t_stb = i;
    end
    check("R4 write one cycle after dir", t_wr - t_dir, 1);
    check("R5 strobe two cycles after write", t_stb - t_wr, 2);
    check("R5 data latched", port_data, d);
    check("R6 other strobe idle", sel ? port_dstb_n : port_astb_n, 1'b1);
    port_wait_n = 1'b1;
    t_rel = -1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      stb = sel ? port_astb_n : port_dstb_n;
      if (t_rel < 0 && stb) begin
        t_rel = i;
        check("R8 ready with strobe release", host_ready, 1'b1);
        check("R7 write line released", port_write_n, 1'b1);
      end
    end
    check("R7 release window", (t_rel >= 12 && t_rel <= 20), 1'b1);
    io_wr = 1'b0;
    cyc(8);
  endtask

  task automatic test_reset;
    check("R1 ready", host_ready, 1'b1);
    check("R1 dir", port_dir, 1'b1);
    check("R1 write", port_write_n, 1'b1);
    check("R1 strobes", {port_dstb_n, port_astb_n}, 2'b11);
    check("R1 flag", timeout_flag, 1'b0);
  endtask

  task automatic test_glitch;
    @(negedge clk);
    host_sel = 1'b0; host_wdata = 8'h3C; io_wr = 1'b1;
    cyc(3);
    port_wait_n = 1'b0;
    cyc(15);
    check("R3 strobe low before glitch", port_dstb_n, 1'b0);
    port_wait_n = 1'b1;
    cyc(2);
    port_wait_n = 1'b0;
    cyc(20);
    check("R3 glitch ignored strobe", port_dstb_n, 1'b0);
    check("R3 glitch ignored ready", host_ready, 1'b0);
    port_wait_n = 1'b1;
    cyc(25);
    check("R3 real release", {port_dstb_n, host_ready}, 2'b11);
    io_wr = 1'b0;
    cyc(8);
  endtask

  task automatic test_holdoff;
    do_write(1'b0, 8'h11);
    // do_write left io_wr low 8 cycles: now start a cycle and end it fast
    @(negedge clk);
    host_wdata = 8'h22; io_wr = 1'b1;
    cyc(3);
    port_wait_n = 1'b0;
    cyc(12);
    port_wait_n = 1'b1;
    cyc(25);
    check("R8 ready back", host_ready, 1'b1);
    io_wr = 1'b0;
    cyc(2);
    io_wr = 1'b1;
    cyc(10);
    check("R11 strobe in holdoff ignored", host_ready, 1'b1);
    io_wr = 1'b0;
    cyc(8);
    io_wr = 1'b1;
    cyc(1);
    check("R11 strobe after holdoff accepted", host_ready, 1'b0);
    port_wait_n = 1'b0;
    cyc(12);
    port_wait_n = 1'b1;
    cyc(25);
    io_wr = 1'b0;
    cyc(8);
  endtask

  task automatic test_timeout;
    @(negedge clk);
    host_sel = 1'b1; host_wdata = 8'h5A; io_wr = 1'b1;
    cyc(1050);
    check("R9 no early timeout", {timeout_flag, host_ready}, 2'b00);
    cyc(70);
    check("R9 flag set", timeout_flag, 1'b1);
    check("R9 ready released", host_ready, 1'b1);
    check("R9 strobes idle", {port_dstb_n, port_astb_n, port_write_n}, 3'b111);
    io_wr = 1'b0;
    cyc(20);
    check("R10 flag sticky", timeout_flag, 1'b1);
    timeout_clr = 1'b1;
    cyc(1);
    timeout_clr = 1'b0;
    cyc(1);
    check("R10 flag cleared", timeout_flag, 1'b0);
    cyc(8);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    test_reset();
    do_write(1'b0, 8'hA5);
    do_write(1'b1, 8'h47);
    test_glitch();
    test_holdoff();
    test_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule